// File: doc/BRIEF.md
# Interleaved Multiphase Dead-Time PWM Generator

This block drives the gates of up to three interleaved half-bridge stages of a class-D power amplifier. One free-running sawtooth counter sets the switching period. Each phase derives its own carrier by subtracting a fixed fraction of the period from that counter. With N active phases, the carriers are spread evenly across the period. The output ripple therefore appears at N times the switching frequency, and the switching frequency itself stays unchanged.

All phases share one duty word. Each phase latches the word only when its own carrier wraps, so a pulse is never cut short. Each phase turns its on/off command into a complementary high-side/low-side pair. A run-time dead-time count keeps both gates off for at least that many clock cycles after every transition. A one-cycle strobe marks the middle of phase 0's commanded pulse, so a converter can sample away from switching edges. With the defaults (10-bit count, 102.4 MHz clock), the period is 1024 cycles at 100 kHz, and a dead-time count of 51 gives about 0.5 µs.

Top module: `ilv_dt_pwm`

## Requirements
- R1: While `rst_n` is low, all gate outputs and the strobe are low. While `en` is low, they go low at the next clock edge and stay low.
- R2: The period is P = 2^CNT_W counts. The shared count restarts at 0 in the first enabled cycle and steps by one each cycle. The phase count N is `ph_num`, with 0 treated as 1 and values above MAX_PH treated as MAX_PH. Phase k < N uses the carrier (count − floor(k·P/N)) mod P. Phases k ≥ N keep both gates low.
- R3: A phase commands its high side while its carrier is below the latched duty. Duty 0 commands it off for the whole period. Duty P−1 commands it on for the whole period.
- R4: For 1 ≤ duty ≤ P−2, dead count D and carrier value c in some cycle, `hs_o[k]` in the following cycle is 1 exactly when D ≤ c < duty. For duty P−1, it is 1 continuously once more than D cycles have passed since enabling.
- R5: For 1 ≤ duty ≤ P−2, `ls_o[k]` in the cycle after carrier value c is 1 exactly when c ≥ duty + D. For duty 0, it is 1 continuously once more than D cycles have passed since enabling.
- R6: A phase never drives both gates high at once. An on-run of D cycles or fewer gives no high-side pulse. An off-run of D cycles or fewer gives no low-side pulse.
- R7: A phase loads `duty` when its own carrier is P−1, so the new value takes effect at carrier 0. While disabled, it loads `duty` every cycle. A change in mid-period has no effect on the rest of that period.
- R8: `smp_stb_o` is high for one cycle. That cycle follows each enabled cycle in which the phase 0 carrier equals floor(latched duty / 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces all gates off |
| ph_num | input | $clog2(MAX_PH+1) | Requested number of active phases |
| duty | input | CNT_W | Shared duty command, in counts of the period |
| dead_cyc | input | DT_W | Dead time, in clock cycles |
| hs_o | output | MAX_PH | High-side gate per phase |
| ls_o | output | MAX_PH | Low-side gate per phase |
| smp_stb_o | output | 1 | Mid-pulse sampling strobe of phase 0 |

## Verification
The bench uses a 64-count period. It sweeps every duty value against every phase-count setting, with no dead time and with five cycles of dead time, and compares every output bit in every cycle of a full steady period.

- The duty sweep separates the full-off and full-on corners from ordinary pulses.
- The phase-count sweep shows whether the carrier offsets and the gating of idle phases are right, including the out-of-range setting 0.
- The non-zero dead time shows whether the blanking sits on the correct side of each edge.

Separate runs cover three further cases. A pulse narrower than the dead time and a dead time longer than the period check the suppression rules. A duty change issued mid-period checks that latching happens only at the wrap.

// File: rtl/ilv_dt_pwm_pkg.sv
package ilv_dt_pwm_pkg;

    // complementary gate pair of one half-bridge
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    // carrier shift of phase idx when nph phases share one period
    function automatic int unsigned carrier_offset(input int unsigned idx,
                                                   input int unsigned nph,
                                                   input int unsigned period);
        if (nph == 0) return 0;
        return (idx * period) / nph;
    endfunction

endpackage

// File: rtl/ilv_carrier_cnt.sv
module ilv_carrier_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    // R2: shared sawtooth, restarts at zero whenever disabled
    always_comb begin
        st_d = st_q;
        if (en) st_d.cnt = st_q.cnt + CNT_W'(1);
        else    st_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/ilv_dead_gen.sv
module ilv_dead_gen
    import ilv_dt_pwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            raw_i,
    input  logic [DT_W-1:0] dt_i,
    output gate_pair_t      gate_o
);

    localparam int RUN_W = DT_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
        gate_pair_t       gate;
    } dg_state_t;

    dg_state_t st_d, st_q;
    logic [RUN_W-1:0] dt_ext;

    assign dt_ext = {1'b0, dt_i};

    // R4/R5/R6: a gate turns on only after its level has held longer than dt
    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else begin
            st_d.lvl = raw_i;
            if (raw_i == st_q.lvl)
                st_d.run = (st_q.run == RUN_MAX) ? st_q.run : st_q.run + RUN_W'(1);
            else
                st_d.run = RUN_W'(1);
            st_d.gate.hi = raw_i  && (st_d.run > dt_ext);
            st_d.gate.lo = !raw_i && (st_d.run > dt_ext);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o = st_q.gate;

endmodule

// File: rtl/ilv_phase_leg.sv
module ilv_phase_leg
    import ilv_dt_pwm_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int DT_W   = 8,
    parameter int MAX_PH = 3,
    parameter int PH_IDX = 0,
    localparam int PH_W  = $clog2(MAX_PH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PH_W-1:0]  n_act,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dt_i,
    output gate_pair_t       gate_o,
    output logic             mid_o
);

    localparam int unsigned     PERIOD = 1 << CNT_W;
    localparam logic [CNT_W-1:0] C_TOP  = '1;
    localparam logic [PH_W-1:0]  IDX_V  = PH_W'(PH_IDX);

    typedef struct packed {
        logic [CNT_W-1:0] duty;
    } leg_state_t;

    leg_state_t st_d, st_q;

    logic [CNT_W-1:0] offs;
    logic [CNT_W-1:0] car;
    logic             active;
    logic             leg_en;
    logic             raw;

    // R2: even spread of carriers; all divisions are by loop constants
    always_comb begin
        offs = '0;
        for (int n = 1; n <= MAX_PH; n++) begin
            if (n_act == PH_W'(n))
                offs = CNT_W'(carrier_offset(PH_IDX, n, PERIOD));
        end
    end

    assign active = (IDX_V < n_act);
    assign leg_en = en && active;
    assign car    = cnt_i - offs;

    // R7: duty taken at the last count of this phase's own period
    always_comb begin
        st_d = st_q;
        if (!leg_en || (car == C_TOP)) st_d.duty = duty_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: full-scale word holds the command on across the wrap
    assign raw = leg_en && ((st_q.duty == C_TOP) || (car < st_q.duty));

    // R8: only phase 0 reports its mid-pulse point
    generate
        if (PH_IDX == 0) begin : g_mid
            assign mid_o = leg_en && (car == (st_q.duty >> 1));
        end else begin : g_nomid
            assign mid_o = 1'b0;
        end
    endgenerate

    ilv_dead_gen #(
        .DT_W (DT_W)
    ) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (leg_en),
        .raw_i  (raw),
        .dt_i   (dt_i),
        .gate_o (gate_o)
    );

endmodule

// File: rtl/ilv_dt_pwm.sv
module ilv_dt_pwm
    import ilv_dt_pwm_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int DT_W   = 8,
    parameter int MAX_PH = 3,
    localparam int PH_W  = $clog2(MAX_PH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PH_W-1:0]   ph_num,
    input  logic [CNT_W-1:0]  duty,
    input  logic [DT_W-1:0]   dead_cyc,
    output logic [MAX_PH-1:0] hs_o,
    output logic [MAX_PH-1:0] ls_o,
    output logic              smp_stb_o
);

    typedef struct packed {
        logic stb;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic [CNT_W-1:0]  cnt;
    logic [PH_W-1:0]   n_act;
    logic [MAX_PH-1:0] mid_w;
    gate_pair_t        gate_w [MAX_PH];

    // R2: clamp the requested phase count into 1..MAX_PH
    always_comb begin
        if (ph_num == '0)                  n_act = PH_W'(1);
        else if (ph_num > PH_W'(MAX_PH))   n_act = PH_W'(MAX_PH);
        else                               n_act = ph_num;
    end

    ilv_carrier_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .cnt_o (cnt)
    );

    generate
        for (genvar k = 0; k < MAX_PH; k++) begin : g_leg
            ilv_phase_leg #(
                .CNT_W  (CNT_W),
                .DT_W   (DT_W),
                .MAX_PH (MAX_PH),
                .PH_IDX (k)
            ) u_leg (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (en),
                .n_act  (n_act),
                .cnt_i  (cnt),
                .duty_i (duty),
                .dt_i   (dead_cyc),
                .gate_o (gate_w[k]),
                .mid_o  (mid_w[k])
            );
            assign hs_o[k] = gate_w[k].hi;
            assign ls_o[k] = gate_w[k].lo;
        end
    endgenerate

    // R8: registered so the strobe lines up with the gate outputs
    always_comb begin
        st_d     = st_q;
        st_d.stb = en && (|mid_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_stb_o = st_q.stb;

endmodule

// File: rtl/ilv_dt_pwm_chk.sv
module ilv_dt_pwm_chk #(
    parameter int DT_W   = 8,
    parameter int MAX_PH = 3,
    localparam int PH_W  = $clog2(MAX_PH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [PH_W-1:0]   ph_num,
    input logic [DT_W-1:0]   dead_cyc,
    input logic [MAX_PH-1:0] hs_o,
    input logic [MAX_PH-1:0] ls_o,
    input logic              smp_stb_o
);

    logic [PH_W-1:0] ph_eff;

    always_comb begin
        ph_eff = ph_num;
        if (ph_num == '0) ph_eff = PH_W'(1);
        if (ph_num > PH_W'(MAX_PH)) ph_eff = PH_W'(MAX_PH);
    end

    p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (hs_o == '0) && (ls_o == '0) && !smp_stb_o);

    p_stb_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb_o |=> !smp_stb_o);

    generate
        for (genvar k = 0; k < MAX_PH; k++) begin : g_ph
            p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !(hs_o[k] && ls_o[k]));

            p_hs_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(ls_o[k]) && ($past(dead_cyc) != '0)) |-> !hs_o[k]);

            p_ls_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(hs_o[k]) && ($past(dead_cyc) != '0)) |-> !ls_o[k]);

            if (k > 0) begin : g_idle
                p_idle_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    (PH_W'(k) >= $past(ph_eff)) |-> (!hs_o[k] && !ls_o[k]));
            end
        end
    endgenerate

endmodule

bind ilv_dt_pwm ilv_dt_pwm_chk #(
    .DT_W   (DT_W),
    .MAX_PH (MAX_PH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ph_num    (ph_num),
    .dead_cyc  (dead_cyc),
    .hs_o      (hs_o),
    .ls_o      (ls_o),
    .smp_stb_o (smp_stb_o)
);

// File: tb/ilv_dt_pwm_bench.sv
module ilv_dt_pwm_bench;

    localparam int CNT_W  = 6;
    localparam int DT_W   = 8;
    localparam int MAX_PH = 3;
    localparam int P      = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [1:0]        ph_num = '0;
    logic [CNT_W-1:0]  duty = '0;
    logic [DT_W-1:0]   dead_cyc = '0;
    logic [MAX_PH-1:0] hs_o;
    logic [MAX_PH-1:0] ls_o;
    logic              smp_stb_o;

    int n_chk = 0;
    int n_fail = 0;
    int n = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ilv_dt_pwm #(
        .CNT_W  (CNT_W),
        .DT_W   (DT_W),
        .MAX_PH (MAX_PH)
    ) u_ilv_dt_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ph_num    (ph_num),
        .duty      (duty),
        .dead_cyc  (dead_cyc),
        .hs_o      (hs_o),
        .ls_o      (ls_o),
        .smp_stb_o (smp_stb_o)
    );

    task automatic tick();
        @(posedge clk);
        n++;
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (n=%0d)", req, act, exp, n);
        end
    endtask

    // steady-state gate levels one cycle after shared count value cnt
    function automatic void exp_pair(input int k, input int cnt, input int d,
                                     input int dtc, input int nph,
                                     output bit h, output bit l);
        int ne;
        int c;
        ne = (nph == 0) ? 1 : ((nph > MAX_PH) ? MAX_PH : nph);
        h = 1'b0;
        l = 1'b0;
        if (k >= ne) return;
        c = ((cnt - (k * P) / ne) % P + P) % P;
        if (d == 0)           l = 1'b1;
        else if (d >= P - 1)  h = 1'b1;
        else begin
            h = (c >= dtc) && (c < d);
            l = (c >= d + dtc);
        end
    endfunction

    task automatic run_steady(input int nph, input int dtc, input int d);
        string tag;
        bit h, l;
        logic [MAX_PH-1:0] eh, el;
        en       = 1'b0;
        ph_num   = 2'(nph);
        dead_cyc = DT_W'(dtc);
        duty     = CNT_W'(d);
        tick();
        tick();
        // R1: disabled, everything low
        check((hs_o == '0) && (ls_o == '0) && !smp_stb_o, "R1 disabled",
              int'({hs_o, ls_o, smp_stb_o}), 0);
        en = 1'b1;
        n  = 0;
        repeat (2 * P) tick();
        if (d == 0 || d == P - 1) tag = "R3";
        else if (dtc != 0)        tag = "R4 R5";
        else                      tag = "R2";
        for (int i = 0; i < P; i++) begin
            tick();
            for (int k = 0; k < MAX_PH; k++) begin
                exp_pair(k, n - 1, d, dtc, nph, h, l);
                eh[k] = h;
                el[k] = l;
            end
            check((hs_o == eh) && (ls_o == el), tag,
                  int'({hs_o, ls_o}), int'({eh, el}));
            // R8: strobe at phase-0 carrier == duty/2
            check(smp_stb_o == (((n - 1) % P) == (d >> 1)), "R8 strobe",
                  int'(smp_stb_o), int'(((n - 1) % P) == (d >> 1)));
        end
    endtask

    initial begin
        int hcnt;
        int lcnt;

        // R1: reset state
        repeat (3) tick();
        check((hs_o == '0) && (ls_o == '0) && !smp_stb_o, "R1 reset",
              int'({hs_o, ls_o, smp_stb_o}), 0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R4 R5 R8: exhaustive duty x phase-count sweep, two dead times
        for (int nph = 0; nph < 4; nph++) begin
            for (int dsel = 0; dsel < 2; dsel++) begin
                for (int d = 0; d < P; d++) begin
                    run_steady(nph, dsel * 5, d);
                end
            end
        end

        // R6: on-run of 3 with dead time 5 -> no high-side pulse
        run_steady(1, 5, 3);
        hcnt = 0;
        lcnt = 0;
        for (int i = 0; i < P; i++) begin
            tick();
            hcnt += int'(hs_o[0]);
            lcnt += int'(ls_o[0]);
        end
        check(hcnt == 0, "R6 narrow pulse hs", hcnt, 0);
        check(lcnt == P - 3 - 5, "R6 narrow pulse ls", lcnt, P - 8);

        // R6: dead time longer than the period suppresses both gates
        run_steady(1, 70, 30);
        hcnt = 0;
        lcnt = 0;
        for (int i = 0; i < P; i++) begin
            tick();
            hcnt += int'(hs_o[0]);
            lcnt += int'(ls_o[0]);
        end
        check((hcnt == 0) && (lcnt == 0), "R6 long dead time", hcnt + lcnt, 0);
        run_steady(1, 70, 0);

        // R7: mid-period duty change waits for the wrap
        run_steady(1, 0, 40);
        while ((n % P) != 5) tick();
        duty = CNT_W'(10);
        for (int i = 0; i < (P - 5) + P; i++) begin
            int c;
            int d;
            tick();
            c = (n - 1) % P;
            d = (i < P - 5) ? 40 : 10;
            check(hs_o[0] == (c < d), "R7 latch hs", int'(hs_o[0]), int'(c < d));
            check(ls_o[0] == (c >= d), "R7 latch ls", int'(ls_o[0]), int'(c >= d));
        end

        // R1: dropping enable clears outputs at the next edge
        run_steady(3, 5, 63);
        en = 1'b0;
        tick();
        check((hs_o == '0) && (ls_o == '0) && !smp_stb_o, "R1 disable",
              int'({hs_o, ls_o, smp_stb_o}), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule